// File: doc/BRIEF.md
# Dual-Strobe Scan Path State Register

This block holds the state of a small sequential network in flip-flops that each have two data inputs, and each input has its own capture strobe. When the functional strobe is pulsed, every flip-flop captures its bit of the next state, which a purely combinational function computes from the present state and the primary input. When the scan strobe is pulsed, every flip-flop captures the output of its neighbour instead, so the register acts as a serial shift chain. A tester can then load any state through one serial input, apply a single functional step, and shift the resulting state out through one serial output pin.

The wrapped network is a four-state demonstration machine with two state bits and one primary input. Both strobes are single-cycle enables in a single clock domain. An asynchronous active-low reset clears the chain. The reset is released through a synchroniser inside the block.

Top module: `scan_path_reg`

## Requirements
- R1: While reset is applied, and for the two clock cycles after `rst_n` rises, the state is S0 (both flip-flops 0). During this time both strobes are ignored.
- R2: On a clock edge with `cap_scan` high, the first flip-flop (Q1) takes `scan_in` and the second flip-flop (Q2) takes the old Q1.
- R3: `scan_out` always shows Q2. After a state is captured, `scan_out` gives Q2 first, and after one scan pulse it gives Q1.
- R4: On a clock edge with `cap_func` high and `cap_scan` low, the state moves to the next state given by the table below.
  - S0: x=0 goes to S0, x=1 goes to S1.
  - S1: x=0 goes to S0, x=1 goes to S2.
  - S2: x=0 goes to S3, x=1 goes to S2.
  - S3: x=0 goes to S1, x=1 goes to S3.
- R5: If `cap_scan` and `cap_func` are high on the same edge, the scan shift of R2 happens and the functional capture does not.
- R6: On an edge with both strobes low, the state is unchanged.
- R7: The state encoding, written as {Q1,Q2}, is S0=00, S1=10, S2=01, S3=11.
- R8: `z_out` is combinational and is 1 exactly in two cases: the state is S3, or the state is S2 with `x_in`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_func | input | 1 | Functional capture strobe (one-cycle enable) |
| cap_scan | input | 1 | Scan shift strobe (one-cycle enable, has priority) |
| scan_in | input | 1 | Serial data into the first flip-flop |
| x_in | input | 1 | Primary input of the demonstration machine |
| z_out | output | 1 | Mealy output of the demonstration machine |
| scan_out | output | 1 | Serial output, the last flip-flop of the chain |

## Verification
Every internal state is observable, because two scan pulses bring both state bits to `scan_out`. An error in the chain wiring or in the strobe priority therefore shows up at most two cycles after the next shift begins. A wrong next-state entry shows up in the unloaded pair right after one functional pulse. A wrong output decode appears on `z_out` in the same cycle that the bad state is loaded.

// File: rtl/scan_path_pkg.sv
package scan_path_pkg;
  localparam int unsigned CHAIN_LEN = 2;

  typedef enum logic [1:0] {
    ST_S0 = 2'b00,
    ST_S1 = 2'b10,
    ST_S2 = 2'b01,
    ST_S3 = 2'b11
  } demo_state_e;
endpackage

// File: rtl/sp_rst_sync.sv
module sp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_core_n = sync_q[STAGES-1];
endmodule

// File: rtl/sp_cell.sv
module sp_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic cap_f,
  input  logic cap_s,
  input  logic d_f,
  input  logic d_s,
  output logic q
);
  logic q_nxt;
  logic q_en;

  // scan capture dominates functional capture
  always_comb begin
    q_en  = cap_s | cap_f;
    q_nxt = cap_s ? d_s : d_f;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= 1'b0;
    else if (q_en) q <= q_nxt;
  end
endmodule

// File: rtl/sp_chain.sv
module sp_chain #(
  parameter int unsigned LEN = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cap_f,
  input  logic           cap_s,
  input  logic           ser_in,
  input  logic [LEN-1:0] func_d,
  output logic [LEN-1:0] q
);
  logic [LEN-1:0] link_d;

  assign link_d[0] = ser_in;

  for (genvar i = 0; i < LEN; i++) begin : g_cell
    if (i > 0) begin : g_link
      assign link_d[i] = q[i-1];
    end
    sp_cell u_cell (
      .clk  (clk),
      .rst_n(rst_n),
      .cap_f(cap_f),
      .cap_s(cap_s),
      .d_f  (func_d[i]),
      .d_s  (link_d[i]),
      .q    (q[i])
    );
  end
endmodule

// File: rtl/sp_demo_logic.sv
module sp_demo_logic
  import scan_path_pkg::*;
(
  input  logic q1,
  input  logic q2,
  input  logic x,
  output logic n1,
  output logic n2,
  output logic z
);
  demo_state_e cur;
  demo_state_e nxt;

  always_comb begin
    cur = demo_state_e'({q1, q2});
    unique case (cur)
      ST_S0:   nxt = x ? ST_S1 : ST_S0;
      ST_S1:   nxt = x ? ST_S2 : ST_S0;
      ST_S2:   nxt = x ? ST_S2 : ST_S3;
      default: nxt = x ? ST_S3 : ST_S1;
    endcase
    n1 = nxt[1];
    n2 = nxt[0];
    z  = (cur == ST_S3) | ((cur == ST_S2) & x);
  end
endmodule

// File: rtl/scan_path_reg.sv
module scan_path_reg
  import scan_path_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cap_func,
  input  logic cap_scan,
  input  logic scan_in,
  input  logic x_in,
  output logic z_out,
  output logic scan_out
);
  localparam int unsigned LEN = CHAIN_LEN;

  logic           rst_core_n;
  logic [LEN-1:0] chain_q;
  logic [LEN-1:0] func_d;
  logic           n1;
  logic           n2;

  sp_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_core_n(rst_core_n)
  );

  // chain position 0 is Q1, position 1 is Q2
  sp_demo_logic u_logic (
    .q1(chain_q[0]),
    .q2(chain_q[1]),
    .x (x_in),
    .n1(n1),
    .n2(n2),
    .z (z_out)
  );

  assign func_d = {n2, n1};

  sp_chain #(.LEN(LEN)) u_chain (
    .clk   (clk),
    .rst_n (rst_core_n),
    .cap_f (cap_func),
    .cap_s (cap_scan),
    .ser_in(scan_in),
    .func_d(func_d),
    .q     (chain_q)
  );

  assign scan_out = chain_q[LEN-1];
endmodule

// File: rtl/scan_path_reg_chk.sv
module scan_path_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rst_core_n,
  input logic       cap_func,
  input logic       cap_scan,
  input logic       scan_in,
  input logic       x_in,
  input logic [1:0] chain_q
);
  function automatic logic [1:0] step(input logic a, input logic b, input logic x);
    logic [1:0] r;
    case ({a, b})
      2'b00: r = x ? 2'b10 : 2'b00;
      2'b10: r = x ? 2'b01 : 2'b00;
      2'b01: r = x ? 2'b01 : 2'b11;
      default: r = x ? 2'b11 : 2'b10;
    endcase
    return r;
  endfunction

  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_core_n |=> chain_q == 2'b00);

  a_r2_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_core_n && cap_scan) |=>
      (chain_q[0] == $past(scan_in)) && (chain_q[1] == $past(chain_q[0])));

  a_r4_func_step: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_core_n && cap_func && !cap_scan) |=>
      {chain_q[0], chain_q[1]} == step($past(chain_q[0]), $past(chain_q[1]), $past(x_in)));

  a_r5_scan_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_core_n && cap_func && cap_scan) |=> chain_q[0] == $past(scan_in));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_core_n && !cap_func && !cap_scan) |=> $stable(chain_q));
endmodule

bind scan_path_reg scan_path_reg_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rst_core_n(rst_core_n),
  .cap_func  (cap_func),
  .cap_scan  (cap_scan),
  .scan_in   (scan_in),
  .x_in      (x_in),
  .chain_q   (chain_q)
);

// File: tb/tb_scan_path_reg.sv
`timescale 1ns/1ps
module tb_scan_path_reg;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cap_func = 1'b0;
  logic cap_scan = 1'b0;
  logic scan_in = 1'b0;
  logic x_in = 1'b0;
  logic z_out;
  logic scan_out;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  scan_path_reg dut (
    .clk(clk), .rst_n(rst_n), .cap_func(cap_func), .cap_scan(cap_scan),
    .scan_in(scan_in), .x_in(x_in), .z_out(z_out), .scan_out(scan_out)
  );

  // state index 0..3 <-> {Q1,Q2}
  function automatic logic [1:0] enc(input int s);
    case (s)
      0: return 2'b00;
      1: return 2'b10;
      2: return 2'b01;
      default: return 2'b11;
    endcase
  endfunction

  function automatic int nxt_idx(input int s, input bit x);
    case (s)
      0: return x ? 1 : 0;
      1: return x ? 2 : 0;
      2: return x ? 2 : 3;
      default: return x ? 3 : 1;
    endcase
  endfunction

  function automatic bit z_ref(input int s, input bit x);
    return (s == 3) || (s == 2 && x);
  endfunction

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic shift(input bit b);
    @(negedge clk);
    cap_scan = 1'b1;
    scan_in  = b;
    @(negedge clk);
    cap_scan = 1'b0;
    scan_in  = 1'b0;
  endtask

  task automatic load(input logic [1:0] q12);
    shift(q12[0]);
    shift(q12[1]);
  endtask

  // returns {Q1,Q2}
  task automatic unload(output logic [1:0] q12);
    logic a;
    a = scan_out;
    shift(1'b0);
    q12 = {scan_out, a};
  endtask

  initial begin
    logic [1:0] got;
    repeat (3) @(negedge clk);
    // strobes during synchroniser window must be ignored
    rst_n = 1'b1;
    cap_scan = 1'b1;
    scan_in  = 1'b1;
    cap_func = 1'b1;
    x_in     = 1'b1;
    @(negedge clk);
    @(negedge clk);
    cap_scan = 1'b0;
    scan_in  = 1'b0;
    cap_func = 1'b0;
    x_in     = 1'b0;
    check("R1 scan_out after reset", {1'b0, scan_out}, 2'b00);
    check("R8 z in S0", {1'b0, z_out}, 2'b00);
    unload(got);
    check("R1 reset state S0", got, 2'b00);

    // exhaustive state x input sweep
    for (int s = 0; s < 4; s++) begin
      for (int x = 0; x < 2; x++) begin
        load(enc(s));
        check("R3 scan_out shows Q2 after load", {1'b0, scan_out}, {1'b0, enc(s)[0]});
        x_in = x[0];
        #0;
        check("R8 z_out", {1'b0, z_out}, {1'b0, z_ref(s, x[0])});
        @(negedge clk);
        cap_func = 1'b1;
        @(negedge clk);
        cap_func = 1'b0;
        x_in = 1'b0;
        unload(got);
        check("R4 R7 next state", got, enc(nxt_idx(s, x[0])));
      end
    end

    // shift pattern: three-bit stream through a two-bit chain
    shift(1'b1); shift(1'b0); shift(1'b1);
    check("R2 shift stream", {1'b0, scan_out}, 2'b00);
    shift(1'b0);
    check("R2 shift stream tail", {1'b0, scan_out}, 2'b01);

    // priority: both strobes, scan wins
    for (int s = 0; s < 4; s++) begin
      load(enc(s));
      @(negedge clk);
      cap_func = 1'b1; cap_scan = 1'b1; scan_in = ~enc(s)[1]; x_in = 1'b1;
      @(negedge clk);
      cap_func = 1'b0; cap_scan = 1'b0; scan_in = 1'b0; x_in = 1'b0;
      unload(got);
      check("R5 scan over func", got, {~enc(s)[1], enc(s)[1]});
    end

    // hold: no strobes, x toggling
    load(2'b10);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      x_in = k[0];
      scan_in = ~k[0];
    end
    x_in = 1'b0; scan_in = 1'b0;
    unload(got);
    check("R6 hold without strobes", got, 2'b10);

    // reset mid-run returns to S0
    load(2'b11);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 async clear", {1'b0, scan_out}, 2'b00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    unload(got);
    check("R1 state after reset", got, 2'b00);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule